// File: doc/BRIEF.md
# Memory Arbiter Event Statistics Counter

This block sits next to a memory controller's arbiter and watches one arbitration outcome per clock. Each cycle it sees whether a grant was issued, which client won, whether the access is a read or a write, and the request's side-band flags. These are the high-priority, timeout and bandwidth flags, plus page-miss, auto-precharge and the two bank-arbitration indicators. Two independent gather channels each pick one event kind and count it. A channel can also be limited to one client ID, and it can be conditioned on the level of one chosen priority flag.

A free-running cycle counter advances alongside the channels while gathering is enabled. It stops at a programmable limit, and once it stops the event counters stop as well. Software sets up both channels, starts a window, later stops it, and reads the counts. Dividing an event count by the cycle count gives a utilisation figure. All access goes through a single-cycle 32-bit register port. Commands written to the control register reset, clear, stop or start gathering.

Top module: `arb_evt_stat`

## Requirements
- R1: After rst_ni is released, every readable register returns 0, except the cycle limit at 0xA0, which returns 0xFFFFFFFF.
- R2: The register map is:
  - 0x90: control; command in bits 9:8, read back as last written.
  - 0xA0: cycle limit; read/write.
  - 0xA4: elapsed cycles.
  - 0xA8 and 0xAC: channel 0 and channel 1 configuration; read/write.
  - 0xB8 and 0xBC: channel 0 and channel 1 counts.

  Configuration fields:
  - bits 13:8: client ID.
  - bits 23:16: event code.
  - bits 25:24: flag select.
  - bit 26: client-filter enable.
  - bits 29:28: flag-filter mode.

  Writes to the cycle and count addresses are ignored.
- R3: A control write acts at the clock edge that accepts it. Command 3 starts counting from the next cycle and does not zero the counts. Command 2 freezes all three counters. No counter advances in a cycle that carries a control write, even if a grant is present.
- R4: Command 0 zeroes the three counters, clears both configurations, restores the limit to all ones and stops counting. Command 1 zeroes the three counters and keeps the configurations and the run state.
- R5: While running, the cycle counter advances by one per clock until it equals the limit. The event counters then stop as well, and they never exceed the cycle count.
- R6: Each channel counts one event per matching grant. Event codes:
  - 0: any grant.
  - 1: read.
  - 2: write.
  - 5: bank arbitration AA flag.
  - 6: bank arbitration BB flag.
  - 7: page miss.
  - 8: auto-precharge.

  Codes 9 and above count nothing.
- R7: Event code 3 counts grants whose direction differs from that of the previous grant. History spans idle cycles and disabled periods.
- R8: Event code 4 counts grants won by the same client as the previous grant, so N back-to-back wins add N-1.
- R9: With bit 26 clear, grants of every client are counted. With bit 26 set, only grants whose client ID equals bits 13:8 are counted.
- R10: The flag select picks which flag the filter tests: 0 = high-priority, 1 = timeout, 2 = bandwidth. The filter mode sets when a grant counts: 0 or 3 = always, 1 = only when the selected flag is low, 2 = only when it is high.
- R11: The two channels count independently with their own configurations over the same grant stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_valid_i | input | 1 | Register access valid this cycle |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the same cycle as a read access |
| gnt_valid_i | input | 1 | Arbiter issued a grant this cycle |
| gnt_client_i | input | 6 | Winning client ID |
| gnt_write_i | input | 1 | Granted access is a write |
| gnt_hp_i | input | 1 | High-priority flag of the granted request |
| gnt_tmo_i | input | 1 | Timeout flag of the granted request |
| gnt_bw_i | input | 1 | Bandwidth flag of the granted request |
| gnt_page_miss_i | input | 1 | Granted access misses the open page |
| gnt_auto_pre_i | input | 1 | Granted access uses auto-precharge |
| gnt_bank_aa_i | input | 1 | Bank arbitration AA indicator |
| gnt_bank_bb_i | input | 1 | Bank arbitration BB indicator |

## Verification
Two pairs of functions can land in the same cycle, and the bench provokes each pair on purpose. The first pair is a control write (start, stop or clear) and a grant that matches a channel's event. The bench drives both in one cycle, and the count must leave that grant out. The second pair is the cycle counter reaching its limit while grants keep arriving. There the bench drives a longer stream than the limit, and the count must hold at the number of matching grants inside the window. Both cycle and event counts must stay frozen while gathering remains enabled.

// File: rtl/arb_evt_pkg.sv
package arb_evt_pkg;
  localparam int CLIENT_W = 6;
  localparam int EVT_W    = 8;
  localparam int NUM_CH   = 2;

  localparam logic [7:0] ADDR_CTRL  = 8'h90;
  localparam logic [7:0] ADDR_LIMIT = 8'hA0;
  localparam logic [7:0] ADDR_CLK   = 8'hA4;
  localparam logic [7:0] ADDR_CFG0  = 8'hA8;
  localparam logic [7:0] ADDR_CFG1  = 8'hAC;
  localparam logic [7:0] ADDR_CNT0  = 8'hB8;
  localparam logic [7:0] ADDR_CNT1  = 8'hBC;

  typedef enum logic [1:0] {CMD_RST = 2'd0, CMD_CLR = 2'd1, CMD_HALT = 2'd2, CMD_RUN = 2'd3} cmd_e;
  typedef enum logic [1:0] {PSEL_HP = 2'd0, PSEL_TMO = 2'd1, PSEL_BW = 2'd2, PSEL_NONE = 2'd3} psel_e;
  typedef enum logic [1:0] {PFLT_OFF = 2'd0, PFLT_LOW = 2'd1, PFLT_HIGH = 2'd2, PFLT_RSVD = 2'd3} pflt_e;

  localparam logic [EVT_W-1:0] EV_ANY     = 8'd0;
  localparam logic [EVT_W-1:0] EV_READ    = 8'd1;
  localparam logic [EVT_W-1:0] EV_WRITE   = 8'd2;
  localparam logic [EVT_W-1:0] EV_TURN    = 8'd3;
  localparam logic [EVT_W-1:0] EV_SUCC    = 8'd4;
  localparam logic [EVT_W-1:0] EV_BANK_AA = 8'd5;
  localparam logic [EVT_W-1:0] EV_BANK_BB = 8'd6;
  localparam logic [EVT_W-1:0] EV_PMISS   = 8'd7;
  localparam logic [EVT_W-1:0] EV_APRE    = 8'd8;

  // field positions are software visible
  typedef struct packed {
    logic [1:0]          rsv_31;
    pflt_e               pflt;
    logic                rsv_27;
    logic                client_en;
    psel_e               psel;
    logic [EVT_W-1:0]    evt;
    logic [1:0]          rsv_15;
    logic [CLIENT_W-1:0] client;
    logic [7:0]          rsv_7;
  } chan_cfg_t;

  typedef struct packed {
    logic                vld;
    logic [CLIENT_W-1:0] client;
    logic                wr;
    logic                hp;
    logic                tmo;
    logic                bw;
    logic                pmiss;
    logic                apre;
    logic                bank_aa;
    logic                bank_bb;
  } grant_t;
endpackage

// File: rtl/arb_evt_hist.sv
module arb_evt_hist
  import arb_evt_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  grant_t gnt_i,
  output logic   turn_o,
  output logic   succ_o
);
  logic                prev_vld_q;
  logic                prev_wr_q;
  logic [CLIENT_W-1:0] prev_client_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_vld_q    <= 1'b0;
      prev_wr_q     <= 1'b0;
      prev_client_q <= '0;
    end else if (gnt_i.vld) begin
      prev_vld_q    <= 1'b1;
      prev_wr_q     <= gnt_i.wr;
      prev_client_q <= gnt_i.client;
    end
  end

  assign turn_o = gnt_i.vld && prev_vld_q && (gnt_i.wr != prev_wr_q);
  assign succ_o = gnt_i.vld && prev_vld_q && (gnt_i.client == prev_client_q);

  // a_r8: a repeat win needs the same client as the last grant
  a_r8_succ_same_client: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i.vld && succ_o) |=> (prev_client_q == $past(gnt_i.client)));
endmodule

// File: rtl/arb_evt_qual.sv
module arb_evt_qual
  import arb_evt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  grant_t    gnt_i,
  input  chan_cfg_t cfg_i,
  input  logic      turn_i,
  input  logic      succ_i,
  output logic      hit_o
);
  logic raw_evt, client_ok, flag, prio_ok;

  always_comb begin
    unique case (cfg_i.evt)
      EV_ANY:     raw_evt = gnt_i.vld;
      EV_READ:    raw_evt = gnt_i.vld && !gnt_i.wr;
      EV_WRITE:   raw_evt = gnt_i.vld && gnt_i.wr;
      EV_TURN:    raw_evt = turn_i;
      EV_SUCC:    raw_evt = succ_i;
      EV_BANK_AA: raw_evt = gnt_i.vld && gnt_i.bank_aa;
      EV_BANK_BB: raw_evt = gnt_i.vld && gnt_i.bank_bb;
      EV_PMISS:   raw_evt = gnt_i.vld && gnt_i.pmiss;
      EV_APRE:    raw_evt = gnt_i.vld && gnt_i.apre;
      default:    raw_evt = 1'b0;
    endcase
  end

  always_comb begin
    unique case (cfg_i.psel)
      PSEL_HP:  flag = gnt_i.hp;
      PSEL_TMO: flag = gnt_i.tmo;
      PSEL_BW:  flag = gnt_i.bw;
      default:  flag = 1'b0;
    endcase
  end

  always_comb begin
    unique case (cfg_i.pflt)
      PFLT_LOW:  prio_ok = !flag;
      PFLT_HIGH: prio_ok = flag;
      default:   prio_ok = 1'b1;
    endcase
  end

  assign client_ok = !cfg_i.client_en || (gnt_i.client == cfg_i.client);
  assign hit_o     = raw_evt && client_ok && prio_ok;

  a_r6_hit_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> gnt_i.vld);
  a_r9_client_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && cfg_i.client_en) |-> (gnt_i.client == cfg_i.client));
endmodule

// File: rtl/arb_evt_sat_cnt.sv
module arb_evt_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] lim_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q < lim_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r5_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q >= $past(cnt_q)));
  a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/arb_evt_stat.sv
module arb_evt_stat
  import arb_evt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_valid_i,
  input  logic                reg_write_i,
  input  logic [7:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  input  logic                gnt_valid_i,
  input  logic [CLIENT_W-1:0] gnt_client_i,
  input  logic                gnt_write_i,
  input  logic                gnt_hp_i,
  input  logic                gnt_tmo_i,
  input  logic                gnt_bw_i,
  input  logic                gnt_page_miss_i,
  input  logic                gnt_auto_pre_i,
  input  logic                gnt_bank_aa_i,
  input  logic                gnt_bank_bb_i
);
  localparam logic [CNT_W-1:0] LIM_MAX = '1;

  grant_t     gnt;
  chan_cfg_t  cfg_q   [NUM_CH];
  chan_cfg_t  cfg_new;
  logic [CNT_W-1:0] limit_q, clk_cnt;
  logic [CNT_W-1:0] evt_cnt [NUM_CH];
  logic [NUM_CH-1:0] hit;
  cmd_e       cmd_q, cmd_new;
  logic       run_q, wr_acc, ctl_wr, zero_cnt, win_open, turn, succ;

  assign gnt = '{vld: gnt_valid_i, client: gnt_client_i, wr: gnt_write_i,
                 hp: gnt_hp_i, tmo: gnt_tmo_i, bw: gnt_bw_i,
                 pmiss: gnt_page_miss_i, apre: gnt_auto_pre_i,
                 bank_aa: gnt_bank_aa_i, bank_bb: gnt_bank_bb_i};

  assign wr_acc   = reg_valid_i && reg_write_i;
  assign ctl_wr   = wr_acc && (reg_addr_i == ADDR_CTRL);
  assign cmd_new  = cmd_e'(reg_wdata_i[9:8]);
  assign zero_cnt = ctl_wr && (cmd_new == CMD_RST || cmd_new == CMD_CLR);
  // command cycles never count
  assign win_open = run_q && !ctl_wr && (clk_cnt < limit_q);

  always_comb begin
    cfg_new        = chan_cfg_t'(reg_wdata_i);
    cfg_new.rsv_31 = '0;
    cfg_new.rsv_27 = 1'b0;
    cfg_new.rsv_15 = '0;
    cfg_new.rsv_7  = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      cmd_q   <= CMD_RST;
      limit_q <= LIM_MAX;
    end else if (ctl_wr) begin
      cmd_q <= cmd_new;
      unique case (cmd_new)
        CMD_RST:  begin run_q <= 1'b0; limit_q <= LIM_MAX; end
        CMD_CLR:  run_q <= run_q;
        CMD_HALT: run_q <= 1'b0;
        default:  run_q <= 1'b1;
      endcase
    end else if (wr_acc && reg_addr_i == ADDR_LIMIT) begin
      limit_q <= reg_wdata_i[CNT_W-1:0];
    end
  end

  arb_evt_hist u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gnt_i  (gnt),
    .turn_o (turn),
    .succ_o (succ)
  );

  arb_evt_sat_cnt #(.W(CNT_W)) u_clk_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (zero_cnt),
    .inc_i  (win_open),
    .lim_i  (limit_q),
    .cnt_o  (clk_cnt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [7:0] CFG_ADDR = (c == 0) ? ADDR_CFG0 : ADDR_CFG1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  cfg_q[c] <= '0;
      else if (ctl_wr && cmd_new == CMD_RST)        cfg_q[c] <= '0;
      else if (wr_acc && reg_addr_i == CFG_ADDR)    cfg_q[c] <= cfg_new;
    end

    arb_evt_qual u_qual (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .gnt_i  (gnt),
      .cfg_i  (cfg_q[c]),
      .turn_i (turn),
      .succ_i (succ),
      .hit_o  (hit[c])
    );

    arb_evt_sat_cnt #(.W(CNT_W)) u_evt_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (zero_cnt),
      .inc_i  (win_open && hit[c]),
      .lim_i  (LIM_MAX),
      .cnt_o  (evt_cnt[c])
    );

    a_r5_evt_le_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_cnt[c] <= clk_cnt);
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_valid_i && !reg_write_i) begin
      unique case (reg_addr_i)
        ADDR_CTRL:  reg_rdata_o = 32'(cmd_q) << 8;
        ADDR_LIMIT: reg_rdata_o = 32'(limit_q);
        ADDR_CLK:   reg_rdata_o = 32'(clk_cnt);
        ADDR_CFG0:  reg_rdata_o = cfg_q[0];
        ADDR_CFG1:  reg_rdata_o = cfg_q[1];
        ADDR_CNT0:  reg_rdata_o = 32'(evt_cnt[0]);
        ADDR_CNT1:  reg_rdata_o = 32'(evt_cnt[1]);
        default:    reg_rdata_o = '0;
      endcase
    end
  end

  a_r3_ctl_cycle_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr |=> (clk_cnt <= $past(clk_cnt)));
  a_r3_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !ctl_wr) |=> ($stable(clk_cnt) && $stable(evt_cnt[0]) && $stable(evt_cnt[1])));
  a_r4_zeroed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_cnt |=> (clk_cnt == '0 && evt_cnt[0] == '0 && evt_cnt[1] == '0));
  a_r5_limit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_wr && clk_cnt >= limit_q) |=> $stable(clk_cnt));
endmodule

// File: tb/sim_arb_evt_stat.sv
module sim_arb_evt_stat;
  localparam int CLK_P = 10;
  localparam logic [6:0] F_HP = 7'h01, F_TMO = 7'h02, F_BW = 7'h04, F_PM = 7'h08,
                         F_AP = 7'h10, F_AA = 7'h20, F_BB = 7'h40;
  localparam logic [7:0] A_CTRL = 8'h90, A_LIM = 8'hA0, A_CLK = 8'hA4,
                         A_CFG0 = 8'hA8, A_CFG1 = 8'hAC, A_CNT0 = 8'hB8, A_CNT1 = 8'hBC;
  localparam logic [31:0] C_RST = 32'h000, C_CLR = 32'h100, C_HALT = 32'h200, C_RUN = 32'h300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_valid, reg_write;
  logic [7:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic gnt_valid, gnt_write, hp, tmo, bw, pm, ap, aa, bb;
  logic [5:0] gnt_client;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  arb_evt_stat u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_valid_i(reg_valid), .reg_write_i(reg_write), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .gnt_valid_i(gnt_valid), .gnt_client_i(gnt_client), .gnt_write_i(gnt_write),
    .gnt_hp_i(hp), .gnt_tmo_i(tmo), .gnt_bw_i(bw), .gnt_page_miss_i(pm),
    .gnt_auto_pre_i(ap), .gnt_bank_aa_i(aa), .gnt_bank_bb_i(bb)
  );

  function automatic logic [31:0] cfgw(input logic [5:0] c, input logic [7:0] ev,
                                       input logic [1:0] ps, input logic ce, input logic [1:0] pf);
    return {2'b0, pf, 1'b0, ce, ps, ev, 2'b0, c, 8'h00};
  endfunction

  task automatic clr_in();
    reg_valid = 0; reg_write = 0; reg_addr = 0; reg_wdata = 0;
    gnt_valid = 0; gnt_client = 0; gnt_write = 0;
    {bb, aa, ap, pm, bw, tmo, hp} = 7'h0;
  endtask

  task automatic tick();
    @(posedge clk); #1; clr_in();
  endtask

  task automatic set_gnt(input logic [5:0] c, input logic w, input logic [6:0] fl);
    gnt_valid = 1; gnt_client = c; gnt_write = w;
    {bb, aa, ap, pm, bw, tmo, hp} = fl;
  endtask

  task automatic set_wr(input logic [7:0] a, input logic [31:0] d);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic gnt(input logic [5:0] c, input logic w, input logic [6:0] fl);
    set_gnt(c, w, fl); tick();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    set_wr(a, d); tick();
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_valid = 1; reg_write = 0; reg_addr = a;
    #1 d = reg_rdata;
    reg_valid = 0;
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  // 8 cycles; counts per event worked out in the requirement comments below
  task automatic pattern();
    gnt(6'd3, 1'b0, F_HP | F_PM);
    gnt(6'd3, 1'b0, F_AA);
    tick();
    gnt(6'd7, 1'b1, F_TMO | F_PM | F_AP);
    gnt(6'd7, 1'b1, F_BW | F_BB);
    gnt(6'd3, 1'b0, F_HP | F_TMO | F_AA);
    gnt(6'd3, 1'b1, 7'h0);
    tick();
  endtask

  task automatic run_pair(input string tag, input logic [31:0] c0, input logic [31:0] c1,
                          input int e0, input int e1);
    wr(A_CTRL, C_RST);
    wr(A_CFG0, c0);
    wr(A_CFG1, c1);
    gnt(6'd9, 1'b1, 7'h0);  // history: last grant was a write by client 9
    wr(A_CTRL, C_RUN);
    pattern();
    wr(A_CTRL, C_HALT);
    rd_chk({tag, " ch0"}, A_CNT0, e0);
    rd_chk({tag, " ch1"}, A_CNT1, e1);
    rd_chk({tag, " cycles"}, A_CLK, 32'd8);
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", A_CTRL, 0);
    rd_chk("R1 limit", A_LIM, 32'hFFFF_FFFF);
    rd_chk("R1 cfg0", A_CFG0, 0);
    rd_chk("R1 cfg1", A_CFG1, 0);
    rd_chk("R1 cycles", A_CLK, 0);
    rd_chk("R1 cnt0", A_CNT0, 0);
    rd_chk("R1 cnt1", A_CNT1, 0);
  endtask

  task automatic t_regs();
    wr(A_CFG0, cfgw(6'd5, 8'd7, 2'd1, 1'b1, 2'd2));
    wr(A_CFG1, cfgw(6'd63, 8'd4, 2'd2, 1'b0, 2'd1));
    wr(A_LIM, 32'd100);
    wr(A_CNT0, 32'h55);
    wr(A_CLK, 32'h66);
    rd_chk("R2 cfg0", A_CFG0, cfgw(6'd5, 8'd7, 2'd1, 1'b1, 2'd2));
    rd_chk("R2 cfg1", A_CFG1, cfgw(6'd63, 8'd4, 2'd2, 1'b0, 2'd1));
    rd_chk("R2 limit", A_LIM, 32'd100);
    rd_chk("R2 cnt0 ro", A_CNT0, 0);
    rd_chk("R2 clk ro", A_CLK, 0);
    wr(A_CTRL, C_HALT);
    rd_chk("R2 ctrl", A_CTRL, C_HALT);
  endtask

  task automatic t_events();
    // any=6 read=3 write=3 aa=2 bb=1 pmiss=2 apre=1
    run_pair("R6 any/read", cfgw(0, 8'd0, 0, 0, 0), cfgw(0, 8'd1, 0, 0, 0), 6, 3);
    run_pair("R6 write/aa", cfgw(0, 8'd2, 0, 0, 0), cfgw(0, 8'd5, 0, 0, 0), 3, 2);
    run_pair("R6 bb/pmiss", cfgw(0, 8'd6, 0, 0, 0), cfgw(0, 8'd7, 0, 0, 0), 1, 2);
    run_pair("R6 apre/code9", cfgw(0, 8'd8, 0, 0, 0), cfgw(0, 8'd9, 0, 0, 0), 1, 0);
    // R7 turnaround 4 (incl. write-before-window history); R8 successive 3
    run_pair("R7 R8 turn/succ", cfgw(0, 8'd3, 0, 0, 0), cfgw(0, 8'd4, 0, 0, 0), 4, 3);
  endtask

  task automatic t_filters();
    run_pair("R9 client 3/7", cfgw(6'd3, 0, 0, 1, 0), cfgw(6'd7, 0, 0, 1, 0), 4, 2);
    run_pair("R9 off/client9", cfgw(6'd3, 0, 0, 0, 0), cfgw(6'd9, 0, 0, 1, 0), 6, 0);
    run_pair("R10 hp high/low", cfgw(0, 0, 2'd0, 0, 2'd2), cfgw(0, 0, 2'd0, 0, 2'd1), 2, 4);
    run_pair("R10 tmo/bw high", cfgw(0, 0, 2'd1, 0, 2'd2), cfgw(0, 0, 2'd2, 0, 2'd2), 2, 1);
    run_pair("R10 bw low/mode0", cfgw(0, 0, 2'd2, 0, 2'd1), cfgw(0, 0, 2'd1, 0, 2'd0), 5, 6);
    run_pair("R10 R11 mode3/client+hp", cfgw(0, 0, 2'd0, 0, 2'd3), cfgw(6'd3, 0, 2'd0, 1, 2'd2), 6, 2);
  endtask

  task automatic t_overlap();
    wr(A_CTRL, C_RST);
    wr(A_CFG0, cfgw(0, 0, 0, 0, 0));
    set_wr(A_CTRL, C_RUN); set_gnt(6'd4, 1'b0, 7'h0); tick();
    gnt(6'd4, 1'b0, 7'h0);
    gnt(6'd4, 1'b0, 7'h0);
    set_wr(A_CTRL, C_HALT); set_gnt(6'd4, 1'b0, 7'h0); tick();
    rd_chk("R3 cmd-cycle grant cnt", A_CNT0, 2);
    rd_chk("R3 cmd-cycle cycles", A_CLK, 2);
    repeat (3) gnt(6'd4, 1'b0, 7'h0);
    rd_chk("R3 frozen cnt", A_CNT0, 2);
    rd_chk("R3 frozen cycles", A_CLK, 2);
    wr(A_CTRL, C_RUN);
    gnt(6'd4, 1'b0, 7'h0);
    gnt(6'd4, 1'b0, 7'h0);
    wr(A_CTRL, C_HALT);
    rd_chk("R3 resume cnt", A_CNT0, 4);
    rd_chk("R3 resume cycles", A_CLK, 4);
  endtask

  task automatic t_limit();
    wr(A_CTRL, C_RST);
    wr(A_CFG0, cfgw(0, 8'd0, 0, 0, 0));
    wr(A_CFG1, cfgw(0, 8'd1, 0, 0, 0));
    wr(A_LIM, 32'd3);
    wr(A_CTRL, C_RUN);
    pattern();
    repeat (2) gnt(6'd1, 1'b0, 7'h0);
    rd_chk("R5 cycles at limit", A_CLK, 3);
    rd_chk("R5 cnt0 stops", A_CNT0, 2);
    rd_chk("R5 cnt1 stops", A_CNT1, 2);
    wr(A_CTRL, C_HALT);
  endtask

  task automatic t_clear();
    wr(A_CTRL, C_RST);
    wr(A_CFG0, cfgw(6'd2, 8'd0, 0, 0, 0));
    wr(A_CTRL, C_RUN);
    repeat (3) gnt(6'd2, 1'b1, 7'h0);
    set_wr(A_CTRL, C_CLR); set_gnt(6'd2, 1'b1, 7'h0); tick();
    rd_chk("R4 clear zeroes", A_CNT0, 0);
    rd_chk("R4 ctrl after clear", A_CTRL, C_CLR);
    repeat (2) gnt(6'd2, 1'b1, 7'h0);
    wr(A_CTRL, C_HALT);
    rd_chk("R4 clear keeps run cnt", A_CNT0, 2);
    rd_chk("R4 clear keeps run cycles", A_CLK, 2);
    rd_chk("R4 clear keeps cfg", A_CFG0, cfgw(6'd2, 8'd0, 0, 0, 0));
  endtask

  task automatic t_reset_cmd();
    wr(A_LIM, 32'd50);
    wr(A_CTRL, C_RUN);
    repeat (2) gnt(6'd2, 1'b0, 7'h0);
    wr(A_CTRL, C_RST);
    repeat (2) gnt(6'd2, 1'b0, 7'h0);
    rd_chk("R4 reset cycles", A_CLK, 0);
    rd_chk("R4 reset cnt0", A_CNT0, 0);
    rd_chk("R4 reset cfg0", A_CFG0, 0);
    rd_chk("R4 reset limit", A_LIM, 32'hFFFF_FFFF);
    rd_chk("R4 reset ctrl", A_CTRL, C_RST);
  endtask

  initial begin
    clr_in();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_regs();
    t_events();
    t_filters();
    t_overlap();
    t_limit();
    t_clear();
    t_reset_cmd();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule